// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory is ready for normal traffic. It first holds the device idle for a long power-up pause. During the pause it issues NOP commands and holds clock enable and all data mask bits high. It then closes both banks with a precharge-all command. Next it issues a fixed number of auto-refresh commands, each spaced by the row-cycle time. Last, it writes the mode register from a word that it packs from four configuration inputs.

All timing values are parameters given in clock cycles: the pause, the precharge-to-refresh gap, the refresh-to-refresh gap and the mode-set recovery. The refresh count is a parameter too. Gap values below 2 behave as 2. A single down-counter times every wait and is reloaded at each step. After the mode-set recovery the block raises `init_done_o`. From then on it parks the pins at NOP with the masks released, so a normal access controller can take over the bus.

Top module: `sdram_init_seq`

## Requirements
- R1: For the first PAUSE_CYC cycles after reset release the command is NOP: cs_n low, and ras_n, cas_n and we_n high. Until init_done_o rises, cke_o stays high, every dqm_o bit stays high and init_done_o stays low.
- R2: In cycle PAUSE_CYC the block issues precharge-all: cs_n, ras_n and we_n low, cas_n high. Address bit 10 is high, every other address bit is 0, and the bank is 0.
- R3: The first auto-refresh command comes exactly T_RP_CYC cycles after the precharge, with NOP in between. Auto-refresh is cs_n, ras_n and cas_n low, we_n high, address 0.
- R4: Exactly REFRESH_CNT auto-refresh commands are issued. Each one comes T_RC_CYC cycles after the previous one, with NOP in between.
- R5: The mode-set command follows the last refresh after T_RC_CYC cycles. Mode-set is all four command pins low, with bank 0.
- R6: The mode-set address packs the mode word as follows. Bits 2..0 carry burst_len_i. Bit 3 carries interleave_i. Bits 6..4 are 011 when cas_lat3_i is 1 and 010 when it is 0. Bits 8..7 are 00. Bit 9 carries single_write_i. Bit 10 is 0.
- R7: NOP follows the mode-set command. init_done_o rises exactly T_MRD_CYC cycles after the mode-set cycle.
- R8: Once high, init_done_o stays high until reset. While it is high the pins show NOP with cke_o high, dqm_o all zeros, address 0 and bank 0.
- R9: rst_ni low at any point returns the pins at once to the R1 pause state. After the next release the full sequence replays from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_len_i | input | 3 | Burst length code placed in mode bits 2..0 |
| interleave_i | input | 1 | Burst order: 1 interleaved, 0 sequential |
| cas_lat3_i | input | 1 | CAS latency select: 1 for three, 0 for two |
| single_write_i | input | 1 | Writes are single-beat when 1 |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | DQM_W | Data mask, one bit per byte lane |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank select |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
A wrong count in the down-counter moves a command edge at the pins. The earliest symptom is the precharge arriving in a cycle other than PAUSE_CYC. Later, a refresh or mode-set lands a cycle early or late, and a cycle-exact comparison catches it within one gap. A wrong refresh counter shows as the mode-set appearing one T_RC_CYC window early or late, which means the wrong number of refresh commands. A wrong state decode shows in the very cycle it occurs as an illegal pin pattern or mask value.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_DONE
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  // 11-bit mode word; upper pins are zero-filled by the caller
  function automatic logic [10:0] pack_mode(input logic [2:0] bl, input logic il,
                                            input logic cl3, input logic sw);
    logic [2:0] cl;
    cl = cl3 ? 3'b011 : 3'b010;
    return {1'b0, sw, 2'b00, cl, il, bl};
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= CNT_W'(RESET_VAL);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned REFRESH_CNT = 8,
  parameter int unsigned RP_LOAD     = 1,
  parameter int unsigned RC_LOAD     = 2,
  parameter int unsigned MRD_LOAD    = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output init_state_e      state_o
);

  localparam int unsigned REF_W = $clog2(REFRESH_CNT + 1);

  init_state_e      state_q, state_d;
  logic [REF_W-1:0] ref_left_q, ref_left_d;

  always_comb begin
    state_d    = state_q;
    ref_left_d = ref_left_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_PAUSE:    if (zero_i) state_d = ST_PRE;
      ST_PRE: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(RP_LOAD);
        state_d    = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (zero_i) state_d = ST_REF;
      ST_REF: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(RC_LOAD);
        ref_left_d = ref_left_q - 1'b1;
        state_d    = ST_WAIT_RC;
      end
      ST_WAIT_RC:
        if (zero_i) state_d = (ref_left_q == '0) ? ST_MRS : ST_REF;
      ST_MRS: begin
        load_o     = 1'b1;
        load_val_o = CNT_W'(MRD_LOAD);
        state_d    = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (zero_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PAUSE;
      ref_left_q <= REF_W'(REFRESH_CNT);
    end else begin
      state_q    <= state_d;
      ref_left_q <= ref_left_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 1,
  parameter int unsigned DQM_W  = 2
) (
  input  init_state_e       state_i,
  input  logic [2:0]        burst_len_i,
  input  logic              interleave_i,
  input  logic              cas_lat3_i,
  input  logic              single_write_i,
  output sd_cmd_t           cmd_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  logic [10:0] mode_word;
  assign mode_word = pack_mode(burst_len_i, interleave_i, cas_lat3_i, single_write_i);

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    cke_o  = 1'b1;
    dqm_o  = '1;
    done_o = 1'b0;
    unique case (state_i)
      ST_PRE: begin
        cmd_o      = CMD_PRE;
        addr_o[10] = 1'b1;
      end
      ST_REF:  cmd_o = CMD_REF;
      ST_MRS: begin
        cmd_o        = CMD_MRS;
        addr_o[10:0] = mode_word;
      end
      ST_DONE: begin
        dqm_o  = '0;
        done_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BA_W        = 1,
  parameter int unsigned DQM_W       = 2,
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned T_RP_CYC    = 3,
  parameter int unsigned T_RC_CYC    = 4,
  parameter int unsigned T_MRD_CYC   = 2,
  parameter int unsigned REFRESH_CNT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              interleave_i,
  input  logic              cas_lat3_i,
  input  logic              single_write_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o
);

  // gaps under 2 clamp to 2: one issue cycle plus at least one wait cycle
  localparam int unsigned RP_E   = (T_RP_CYC  < 2) ? 2 : T_RP_CYC;
  localparam int unsigned RC_E   = (T_RC_CYC  < 2) ? 2 : T_RC_CYC;
  localparam int unsigned MRD_E  = (T_MRD_CYC < 2) ? 2 : T_MRD_CYC;
  localparam int unsigned PAU_E  = (PAUSE_CYC < 1) ? 1 : PAUSE_CYC;
  localparam int unsigned MAX_V  = (PAU_E > RC_E) ? ((PAU_E > RP_E) ? PAU_E : RP_E)
                                                  : ((RC_E > RP_E) ? RC_E : RP_E);
  localparam int unsigned MAX_A  = (MAX_V > MRD_E) ? MAX_V : MRD_E;
  localparam int unsigned CNT_W  = $clog2(MAX_A + 1);

  logic             zero, load;
  logic [CNT_W-1:0] load_val;
  init_state_e      state;
  sd_cmd_t          cmd;

  sdram_init_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(PAU_E - 1)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  sdram_init_fsm #(
    .CNT_W      (CNT_W),
    .REFRESH_CNT(REFRESH_CNT),
    .RP_LOAD    (RP_E - 2),
    .RC_LOAD    (RC_E - 2),
    .MRD_LOAD   (MRD_E - 2)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zero_i    (zero),
    .load_o    (load),
    .load_val_o(load_val),
    .state_o   (state)
  );

  sdram_init_pins #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .DQM_W (DQM_W)
  ) i_pins (
    .state_i       (state),
    .burst_len_i   (burst_len_i),
    .interleave_i  (interleave_i),
    .cas_lat3_i    (cas_lat3_i),
    .single_write_i(single_write_i),
    .cmd_o         (cmd),
    .cke_o         (cke_o),
    .dqm_o         (dqm_o),
    .addr_o        (addr_o),
    .ba_o          (ba_o),
    .done_o        (init_done_o)
  );

  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BA_W        = 1,
  parameter int unsigned DQM_W       = 2,
  parameter int unsigned T_RP_CYC    = 3,
  parameter int unsigned T_RC_CYC    = 4,
  parameter int unsigned REFRESH_CNT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic              cke_o,
  input logic [DQM_W-1:0]  dqm_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              init_done_o
);

  localparam int unsigned RP_E = (T_RP_CYC < 2) ? 2 : T_RP_CYC;
  localparam int unsigned RC_E = (T_RC_CYC < 2) ? 2 : T_RC_CYC;

  logic is_nop, is_pre, is_ref, is_mrs;
  assign is_nop = !cs_n_o &&  ras_n_o &&  cas_n_o &&  we_n_o;
  assign is_pre = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;
  assign is_ref = !cs_n_o && !ras_n_o && !cas_n_o &&  we_n_o;
  assign is_mrs = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  logic [15:0] since_q;
  logic        last_pre_q;
  logic [15:0] refs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      last_pre_q <= 1'b0;
      refs_q     <= '0;
    end else begin
      if (!is_nop) begin
        since_q    <= 16'd1;
        last_pre_q <= is_pre;
      end else if (since_q != 16'hffff) begin
        since_q <= since_q + 16'd1;
      end
      if (is_ref) refs_q <= refs_q + 16'd1;
    end
  end

  p_mask_cke_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (&dqm_o) && cke_o);

  p_pre_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o == (ADDR_W'(1) << 10) && ba_o == '0);

  p_first_ref_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref && last_pre_q |-> since_q == 16'(RP_E));

  p_ref_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref && !last_pre_q |-> since_q == 16'(RC_E));

  p_mrs_after_refs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> since_q == 16'(RC_E) && refs_q == 16'(REFRESH_CNT) && ba_o == '0);

  p_mrs_then_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop && dqm_o == '0 && addr_o == '0);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .DQM_W      (DQM_W),
  .T_RP_CYC   (T_RP_CYC),
  .T_RC_CYC   (T_RC_CYC),
  .REFRESH_CNT(REFRESH_CNT)
) i_sdram_init_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .cke_o      (cke_o),
  .dqm_o      (dqm_o),
  .addr_o     (addr_o),
  .ba_o       (ba_o),
  .init_done_o(init_done_o)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int ADDR_W = 11;
  localparam int BA_W   = 1;
  localparam int DQM_W  = 2;
  localparam int PAUSE  = 10000;
  localparam int T_RP   = 3;
  localparam int T_RC   = 4;
  localparam int T_MRD  = 2;
  localparam int NREF   = 8;

  localparam int C_PRE  = PAUSE;
  localparam int C_REF0 = PAUSE + T_RP;
  localparam int C_MRS  = C_REF0 + NREF * T_RC;
  localparam int C_DONE = C_MRS + T_MRD;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] burst_len;
  logic interleave, cas_lat3, single_write;
  logic cs_n, ras_n, cas_n, we_n, cke, done;
  logic [DQM_W-1:0]  dqm;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .PAUSE_CYC(PAUSE),
    .T_RP_CYC(T_RP), .T_RC_CYC(T_RC), .T_MRD_CYC(T_MRD), .REFRESH_CNT(NREF)
  ) i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .burst_len_i(burst_len),
    .interleave_i(interleave), .cas_lat3_i(cas_lat3), .single_write_i(single_write),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .cke_o(cke), .dqm_o(dqm), .addr_o(addr), .ba_o(ba), .init_done_o(done)
  );

  // {cs_n,ras_n,cas_n,we_n}
  function automatic logic [3:0] exp_cmd(int c);
    if (c == C_PRE) return 4'b0010;
    if (c >= C_REF0 && c < C_MRS && ((c - C_REF0) % T_RC) == 0) return 4'b0001;
    if (c == C_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(int c);
    if (c == C_PRE) return ADDR_W'(1) << 10;
    if (c == C_MRS)
      return ADDR_W'({1'b0, single_write, 2'b00, (cas_lat3 ? 3'b011 : 3'b010),
                      interleave, burst_len});
    return '0;
  endfunction

  function automatic string req_of(int c);
    if (c < C_PRE)  return "R1";
    if (c == C_PRE) return "R2";
    if (c < C_REF0 + T_RC) return "R3";
    if (c < C_MRS)  return "R4";
    if (c == C_MRS) return "R6";
    if (c < C_DONE) return "R7";
    return "R8";
  endfunction

  task automatic check_cycle(int c, string req);
    logic [3:0] ec;
    logic [ADDR_W-1:0] ea;
    logic [DQM_W-1:0] ed;
    logic edn;
    ec  = exp_cmd(c);
    ea  = exp_addr(c);
    edn = (c >= C_DONE);
    ed  = edn ? '0 : '1;
    checks++;
    if ({cs_n, ras_n, cas_n, we_n} !== ec || addr !== ea || ba !== '0 ||
        dqm !== ed || cke !== 1'b1 || done !== edn) begin
      errors++;
      $display("FAIL %s cycle %0d: cmd=%b addr=%h ba=%h dqm=%b cke=%b done=%b exp cmd=%b addr=%h ba=0 dqm=%b cke=1 done=%b",
               req, c, {cs_n, ras_n, cas_n, we_n}, addr, ba, dqm, cke, done, ec, ea, ed, edn);
    end
  endtask

  // abort_at < 0: run to completion; otherwise reset in that cycle (R9)
  task automatic run_seq(logic [2:0] bl, logic il, logic cl3, logic sw, int abort_at);
    burst_len = bl; interleave = il; cas_lat3 = cl3; single_write = sw;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    #1 checks++;
    if ({cs_n, ras_n, cas_n, we_n} !== 4'b0111 || dqm !== '1 || cke !== 1'b1 || done !== 1'b0) begin
      errors++;
      $display("FAIL R9 in reset: cmd=%b dqm=%b cke=%b done=%b exp cmd=0111 dqm=11 cke=1 done=0",
               {cs_n, ras_n, cas_n, we_n}, dqm, cke, done);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 0; c <= C_DONE + 6; c++) begin
      #1;
      if (abort_at >= 0 && c == abort_at) begin
        rst_ni = 1'b0;
        #1 checks++;
        if ({cs_n, ras_n, cas_n, we_n} !== 4'b0111 || dqm !== '1 || done !== 1'b0) begin
          errors++;
          $display("FAIL R9 abort at %0d: cmd=%b dqm=%b done=%b exp cmd=0111 dqm=11 done=0",
                   c, {cs_n, ras_n, cas_n, we_n}, dqm, done);
        end
        return;
      end
      check_cycle(c, req_of(c));
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    burst_len = 3'd0; interleave = 1'b0; cas_lat3 = 1'b0; single_write = 1'b0;
    run_seq(3'b000, 1'b0, 1'b0, 1'b0, -1);           // R6 all-low fields, CL2
    run_seq(3'b111, 1'b1, 1'b1, 1'b1, -1);           // R6 all-high fields, CL3
    run_seq(3'b011, 1'b0, 1'b1, 1'b0, C_REF0 + 5);    // R9 reset during refreshes
    run_seq(3'b010, 1'b1, 1'b0, 1'b1, -1);           // R9 replay after abort
    for (int i = 0; i < 2; i++)
      run_seq(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), -1);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule